// File: doc/BRIEF.md
# CCM Counter Block Generator

This block supplies the counter blocks that the CTR half of a CCM engine encrypts. Each block is 128 bits. It holds a flags octet, a 104-bit per-frame nonce and a 16-bit big-endian block counter. The nonce is built from the frame's priority octet, its 48-bit transmitter address and its 48-bit packet number. It is captured once, when a frame starts.

A frame begins with a one-cycle `start_i` pulse. The block clears its counter to zero and then waits out one cipher latency before it raises `valid_o`. The cipher XORs its output for counter value 0 with the 64-bit CBC-MAC result to form the final MIC. Each later counter value covers one 128-bit payload block. The cipher pulses `adv_i` when it has taken the current block. The generator then increments the counter and waits the cipher latency again before it offers the next block. The cipher itself and the XOR with payload belong to the neighbouring blocks.

Top module: `ccm_ctr_blockgen`

## Requirements
- R1: While reset is asserted and after it is released, `valid_o` is low and the nonce and counter fields of `blk_o` are all zero.
- R2: `blk_o` bit fields, from most significant down: [127:120] flags octet equal to CNT_W/8-1 (0x01 by default), [119:112] priority octet, [111:64] transmitter address, [63:16] packet number with its most significant byte first, [15:0] block counter, big-endian.
- R3: The clock edge that samples `start_i` high captures `prio_i`, `addr_i` and `pn_i` into the nonce and clears the block counter to zero.
- R4: `valid_o` rises exactly WAIT_CYCLES+1 cycles (11 by default) after the edge that samples `start_i`. It rises exactly WAIT_CYCLES cycles (10 by default) after an edge that accepts an advance.
- R5: While `valid_o` is high and neither `adv_i` nor `start_i` is sampled high, `valid_o` stays high and `blk_o` holds its value, whatever the nonce inputs do.
- R6: An edge that samples `adv_i` high while `valid_o` is high increments the counter by one, and `valid_o` is low in the following cycle.
- R7: `adv_i` sampled high while `valid_o` is low has no effect on the counter or on the timing.
- R8: `start_i` is accepted in every state. It aborts the current frame, loads the new nonce, zeroes the counter and restarts the R4 timing.
- R9: The counter wraps from its all-ones value to zero with no other effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Frame start pulse |
| prio_i | input | 8 | Priority octet of the nonce |
| addr_i | input | 48 | Transmitter address of the nonce |
| pn_i | input | 48 | Packet number of the nonce |
| adv_i | input | 1 | Cipher has taken the current block |
| blk_o | output | 128 | Counter block |
| valid_o | output | 1 | Counter block is ready |

## Verification
The assertions assume that `start_i` and `adv_i` are single-cycle pulses. They also assume that the nonce inputs matter only in the cycle `start_i` is high. They do not assume that the cipher pulses `adv_i` only while `valid_o` is high. For that reason the bench deliberately pulses advance while a block is pending, and changes the nonce inputs without a start pulse. This confirms that both are ignored. A second instance with an 8-bit counter and a two-cycle wait reaches the wrap point quickly. The default instance would need over 700,000 cycles to get there.

// File: rtl/ctrgen_pkg.sv
package ctrgen_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_LOAD  = 2'd1,
      ST_WAIT  = 2'd2,
      ST_VALID = 2'd3
   } seq_state_t;
endpackage

// File: rtl/ctrgen_nonce.sv
module ctrgen_nonce #(
   parameter int PRI_W  = 8,
   parameter int ADDR_W = 48,
   parameter int PN_W   = 48,
   localparam int NONCE_W = PRI_W + ADDR_W + PN_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_i,
   input  logic [PRI_W-1:0]   prio_i,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic [PN_W-1:0]    pn_i,
   output logic [NONCE_W-1:0] nonce_o
);
   // Order is fixed: priority, address, then packet number (MSB first).
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         nonce_o <= '0;
      else if (load_i)
         nonce_o <= {prio_i, addr_i, pn_i};
   end
endmodule

// File: rtl/ctrgen_count.sv
module ctrgen_count #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             step_i,
   output logic [CNT_W-1:0] count_o
);
   // Natural modulo-2^CNT_W wrap.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count_o <= '0;
      else if (clear_i)
         count_o <= '0;
      else if (step_i)
         count_o <= count_o + 1'b1;
   end
endmodule

// File: rtl/ctrgen_seq.sv
module ctrgen_seq
   import ctrgen_pkg::*;
#(
   parameter int WAIT_CYCLES = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic adv_i,
   output logic load_o,
   output logic step_o,
   output logic valid_o
);
   seq_state_t state_q, state_d;
   logic       wait_done;

   generate
      if (WAIT_CYCLES > 1) begin : g_wait_cnt
         localparam int WC_W = $clog2(WAIT_CYCLES);
         logic [WC_W-1:0] wcnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               wcnt_q <= '0;
            else if (state_q != ST_WAIT)
               wcnt_q <= '0;
            else
               wcnt_q <= wcnt_q + 1'b1;
         end
         assign wait_done = (wcnt_q == WC_W'(WAIT_CYCLES - 1));
      end else begin : g_wait_one
         assign wait_done = 1'b1;
      end
   endgenerate

   always_comb begin
      state_d = state_q;
      if (start_i)
         state_d = ST_LOAD;
      else begin
         unique case (state_q)
            ST_IDLE:  state_d = ST_IDLE;
            ST_LOAD:  state_d = ST_WAIT;
            ST_WAIT:  if (wait_done) state_d = ST_VALID;
            ST_VALID: if (adv_i) state_d = ST_WAIT;
            default:  state_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state_q <= ST_IDLE;
      else
         state_q <= state_d;
   end

   assign load_o  = start_i;
   assign step_o  = (state_q == ST_VALID) && adv_i && !start_i;
   assign valid_o = (state_q == ST_VALID);
endmodule

// File: rtl/ccm_ctr_blockgen.sv
module ccm_ctr_blockgen #(
   parameter int PRI_W       = 8,
   parameter int ADDR_W      = 48,
   parameter int PN_W        = 48,
   parameter int CNT_W       = 16,
   parameter int WAIT_CYCLES = 10,
   localparam int NONCE_W = PRI_W + ADDR_W + PN_W,
   localparam int BLK_W   = 8 + NONCE_W + CNT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [PRI_W-1:0]  prio_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [PN_W-1:0]   pn_i,
   input  logic              adv_i,
   output logic [BLK_W-1:0]  blk_o,
   output logic              valid_o
);
   localparam int        CNT_OCTETS = CNT_W / 8;
   localparam logic [7:0] FLAGS     = 8'(CNT_OCTETS - 1);

   generate
      if (CNT_W < 8 || CNT_W > 64 || (CNT_W % 8) != 0) begin : g_bad_cnt
         $error("CNT_W must be a whole number of octets between 8 and 64");
      end
      if (WAIT_CYCLES < 1) begin : g_bad_wait
         $error("WAIT_CYCLES must be at least 1");
      end
      if ((PRI_W % 8) != 0 || (ADDR_W % 8) != 0 || (PN_W % 8) != 0) begin : g_bad_nonce
         $error("nonce fields must be whole octets");
      end
   endgenerate

   logic               load_w, step_w;
   logic [NONCE_W-1:0] nonce_w;
   logic [CNT_W-1:0]   count_w;

   ctrgen_seq #(.WAIT_CYCLES(WAIT_CYCLES)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .adv_i   (adv_i),
      .load_o  (load_w),
      .step_o  (step_w),
      .valid_o (valid_o)
   );

   ctrgen_nonce #(.PRI_W(PRI_W), .ADDR_W(ADDR_W), .PN_W(PN_W)) u_nonce (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load_w),
      .prio_i  (prio_i),
      .addr_i  (addr_i),
      .pn_i    (pn_i),
      .nonce_o (nonce_w)
   );

   ctrgen_count #(.CNT_W(CNT_W)) u_count (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (load_w),
      .step_i  (step_w),
      .count_o (count_w)
   );

   assign blk_o = {FLAGS, nonce_w, count_w};
endmodule

// File: rtl/ctrgen_checker.sv
module ctrgen_checker #(
   parameter int NONCE_W     = 104,
   parameter int CNT_W       = 16,
   parameter int WAIT_CYCLES = 10,
   localparam int BLK_W = 8 + NONCE_W + CNT_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             adv_i,
   input logic [BLK_W-1:0] blk_o,
   input logic             valid_o
);
   logic [CNT_W-1:0]   cnt_f;
   logic [NONCE_W-1:0] nonce_f;
   logic [31:0]        low_run;

   assign cnt_f   = blk_o[CNT_W-1:0];
   assign nonce_f = blk_o[CNT_W+NONCE_W-1:CNT_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         low_run <= '0;
      else if (valid_o)
         low_run <= '0;
      else if (low_run != 32'hFFFF_FFFF)
         low_run <= low_run + 1'b1;
   end

   // R3: start clears counter and drops valid
   a_r3_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (cnt_f == '0) && !valid_o);

   // R4: never offered sooner than one cipher latency after going low
   a_r4_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid_o) |-> (low_run >= 32'(WAIT_CYCLES)));

   // R5: pending block is held
   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !adv_i && !start_i) |=> (valid_o && $stable(blk_o)));

   // R6: accepted advance steps the counter by one and drops valid
   a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && adv_i && !start_i) |=> (!valid_o && (cnt_f == CNT_W'($past(cnt_f) + 1'b1))));

   // R7: advance without a pending block is ignored
   a_r7_ignore_adv: assert property (@(posedge clk) disable iff (!rst_n)
      (!valid_o && !start_i) |=> $stable(cnt_f));

   // R2: nonce changes only on start
   a_r2_nonce_latched: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> $stable(nonce_f));
endmodule

bind ccm_ctr_blockgen ctrgen_checker #(
   .NONCE_W     (NONCE_W),
   .CNT_W       (CNT_W),
   .WAIT_CYCLES (WAIT_CYCLES)
) u_ctrgen_checker (
   .clk     (clk),
   .rst_n   (rst_n),
   .start_i (start_i),
   .adv_i   (adv_i),
   .blk_o   (blk_o),
   .valid_o (valid_o)
);

// File: tb/test_ccm_ctr_blockgen.sv
module test_ccm_ctr_blockgen;
   localparam int CLK_PERIOD = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0, adv = 1'b0;
   logic         s_start = 1'b0, s_adv = 1'b0;
   logic [7:0]   prio = '0;
   logic [47:0]  addr = '0, pn = '0;
   logic [127:0] blk;
   logic         valid;
   logic [119:0] s_blk;
   logic         s_valid;
   int           n_checks = 0, n_fail = 0;
   bit           done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ccm_ctr_blockgen i_ccm_ctr_blockgen (
      .clk(clk), .rst_n(rst_n), .start_i(start), .prio_i(prio), .addr_i(addr),
      .pn_i(pn), .adv_i(adv), .blk_o(blk), .valid_o(valid));

   ccm_ctr_blockgen #(.CNT_W(8), .WAIT_CYCLES(2)) i_ccm_ctr_blockgen_small (
      .clk(clk), .rst_n(rst_n), .start_i(s_start), .prio_i(prio), .addr_i(addr),
      .pn_i(pn), .adv_i(s_adv), .blk_o(s_blk), .valid_o(s_valid));

   task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [127:0] exp_blk(input logic [7:0] p, input logic [47:0] a,
                                            input logic [47:0] n, input logic [15:0] c);
      return {8'h01, p, a, n, c};
   endfunction

   task automatic ticks(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_start(input logic [7:0] p, input logic [47:0] a, input logic [47:0] n);
      @(negedge clk);
      prio = p; addr = a; pn = n; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic do_adv();
      @(negedge clk);
      adv = 1'b1;
      @(negedge clk);
      adv = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 valid in reset", 128'(valid), 128'd0);
      check("R1 block in reset", blk, {8'h01, 120'd0});
      @(negedge clk); rst_n = 1'b1;
      ticks(2);
      check("R1 valid after reset", 128'(valid), 128'd0);
      check("R1 block after reset", blk, {8'h01, 120'd0});
   endtask

   task automatic t_basic();
      do_start(8'h5A, 48'h0123_4567_89AB, 48'hA1B2_C3D4_E5F6);
      ticks(10);
      check("R4 not valid at 10 cycles", 128'(valid), 128'd0);
      ticks(1);
      check("R4 valid at 11 cycles", 128'(valid), 128'd1);
      check("R2 R3 first block layout", blk,
            exp_blk(8'h5A, 48'h0123_4567_89AB, 48'hA1B2_C3D4_E5F6, 16'h0000));
      prio = 8'hFF; addr = '1; pn = 48'h1;
      for (int i = 0; i < 5; i++) begin
         ticks(1);
         check("R5 valid held", 128'(valid), 128'd1);
         check("R5 block held, nonce inputs ignored", blk,
               exp_blk(8'h5A, 48'h0123_4567_89AB, 48'hA1B2_C3D4_E5F6, 16'h0000));
      end
   endtask

   task automatic t_advance();
      for (int k = 1; k <= 3; k++) begin
         do_adv();
         check("R6 valid drops after advance", 128'(valid), 128'd0);
         check("R6 counter stepped", 128'(blk[15:0]), 128'(k));
         ticks(9);
         check("R4 not valid 9 cycles after advance", 128'(valid), 128'd0);
         ticks(1);
         check("R4 valid 10 cycles after advance", 128'(valid), 128'd1);
      end
      check("R2 nonce kept across blocks", blk,
            exp_blk(8'h5A, 48'h0123_4567_89AB, 48'hA1B2_C3D4_E5F6, 16'h0003));
   endtask

   task automatic t_ignore();
      do_adv();
      ticks(2);
      adv = 1'b1; ticks(1); adv = 1'b0;
      ticks(1);
      adv = 1'b1; ticks(1); adv = 1'b0;
      check("R7 counter unchanged by advance while waiting", 128'(blk[15:0]), 128'd4);
      ticks(4);
      check("R7 timing unchanged", 128'(valid), 128'd0);
      ticks(1);
      check("R7 valid at normal time", 128'(valid), 128'd1);
      check("R7 counter after ignored advances", 128'(blk[15:0]), 128'd4);
   endtask

   task automatic t_restart();
      do_start(8'h11, 48'hCAFE_0000_BEEF, 48'h0000_0000_0042);
      check("R8 restart from valid drops valid", 128'(valid), 128'd0);
      check("R8 R3 new nonce and zero counter", blk,
            exp_blk(8'h11, 48'hCAFE_0000_BEEF, 48'h0000_0000_0042, 16'h0000));
      ticks(11);
      check("R8 valid 11 cycles after restart", 128'(valid), 128'd1);
      do_adv();
      ticks(4);
      do_start(8'h22, 48'h1111_2222_3333, 48'h4444_5555_6666);
      check("R8 restart during wait clears counter", 128'(blk[15:0]), 128'd0);
      ticks(10);
      check("R8 R4 no early valid after restart in wait", 128'(valid), 128'd0);
      ticks(1);
      check("R8 R4 valid after restart in wait", 128'(valid), 128'd1);
      check("R8 block after restart", blk,
            exp_blk(8'h22, 48'h1111_2222_3333, 48'h4444_5555_6666, 16'h0000));
   endtask

   task automatic s_wait_valid(output bit ok);
      ok = 1'b0;
      for (int i = 0; i < 50; i++) begin
         if (s_valid) begin ok = 1'b1; break; end
         ticks(1);
      end
   endtask

   task automatic t_wrap();
      bit ok;
      @(negedge clk); s_start = 1'b1; @(negedge clk); s_start = 1'b0;
      s_wait_valid(ok);
      check("R9 small instance reaches valid", 128'(ok), 128'd1);
      check("R2 small flags octet", 128'(s_blk[119:112]), 128'h00);
      for (int k = 0; k < 255; k++) begin
         @(negedge clk); s_adv = 1'b1; @(negedge clk); s_adv = 1'b0;
         s_wait_valid(ok);
      end
      check("R9 counter at all-ones", 128'(s_blk[7:0]), 128'hFF);
      @(negedge clk); s_adv = 1'b1; @(negedge clk); s_adv = 1'b0;
      check("R9 counter wraps to zero", 128'(s_blk[7:0]), 128'h00);
      s_wait_valid(ok);
      check("R9 valid after wrap", 128'(ok), 128'd1);
      check("R9 nonce intact after wrap", 128'(s_blk[111:8]),
            128'({8'h22, 48'h1111_2222_3333, 48'h4444_5555_6666}));
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      ticks(3);
      t_reset();
      t_basic();
      t_advance();
      t_ignore();
      t_restart();
      t_wrap();
      ticks(2);
      finish_run();
   end
endmodule